// File: doc/BRIEF.md
# Reordering Command Queue with Placement

This block holds a fixed number of memory commands and chooses each command's place in the execution order at the moment it arrives. Each command carries a read/write flag, a bank, a row, a column, a source ID, a priority and a write-buffer index. On arrival the new command is compared with everything already queued. The result gives one insertion slot. Entries behind that slot move back by one. Entries already queued never change order among themselves.

The head of the queue is always entry 0. It is offered to the memory core through a valid/ready handshake, and each pop shifts the remaining entries toward the head. A global placement enable and six per-rule enables are configuration inputs. With placement disabled, the block is a plain in-order FIFO.

The placement rules have a fixed order of importance. First, collisions on address, source ID or write-buffer index fix the earliest slot the command may take. Second, priority picks a slot after that point. Third, among slots that tie on priority, bank splitting is preferred over read/write grouping. When several slots still tie, the latest one is chosen.

Top module: `reorder_cmdq`

## Requirements
- R1: After reset the queue is empty: out_valid_o is 0 and in_ready_o is 1.
- R2: With place_en_i at 0, commands leave in arrival order whatever their fields and rule enables.
- R3: A command pushed into an empty queue becomes the head on the next cycle. Queued commands keep their relative order, and each pop moves every entry one step toward the head.
- R4: A head that is offered (out_valid_o high, out_ready_i low) stays unchanged, and no new command is placed ahead of it. If the head is popped in the same cycle as a push, the new command may take the new head slot.
- R5: With rule_en_i[0] set, a new command goes behind the last queued entry that has the same bank and row.
- R6: With rule_en_i[1] set, a new command goes behind the last queued entry that has the same source ID.
- R7: With rule_en_i[2] set, a new command goes behind the last queued entry that has the same write-buffer index.
- R8: With rule_en_i[3] set, a lower priority value means more urgent. After the collision bound, a new command goes just ahead of the first entry whose priority value is strictly larger; if there is none, it goes to the tail. With this bit clear, priority is ignored.
- R9: With rule_en_i[4] set, among slots that tie on priority, a slot whose preceding entry is in a different bank is preferred. Of several such slots, the latest is taken.
- R10: With rule_en_i[5] set, among remaining tied slots, a slot whose preceding or following entry has the same read/write flag is preferred. This preference ranks below bank splitting.
- R11: When the queue holds DEPTH entries and out_ready_i is low, in_ready_o is 0, and a command offered then is dropped.
- R12: When the queue is full and a pop and a push happen in the same cycle, both complete and the queue stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| place_en_i | input | 1 | 1: placement rules apply; 0: plain FIFO |
| rule_en_i | input | 6 | Rule enables: 0 address, 1 source, 2 write buffer, 3 priority, 4 bank split, 5 read/write group |
| in_valid_i | input | 1 | New command offered |
| in_ready_o | output | 1 | Queue accepts the offered command |
| in_wr_i | input | 1 | 1 write, 0 read |
| in_bank_i | input | BANK_W | Bank |
| in_row_i | input | ROW_W | Row |
| in_col_i | input | COL_W | Column |
| in_src_i | input | SRC_W | Source ID |
| in_prio_i | input | PRIO_W | Priority, 0 most urgent |
| in_wb_i | input | WB_W | Write-buffer index |
| out_valid_o | output | 1 | Head entry present |
| out_ready_i | input | 1 | Core takes the head |
| out_wr_o | output | 1 | Head read/write flag |
| out_bank_o | output | BANK_W | Head bank |
| out_row_o | output | ROW_W | Head row |
| out_col_o | output | COL_W | Head column |
| out_src_o | output | SRC_W | Head source ID |
| out_prio_o | output | PRIO_W | Head priority |
| out_wb_o | output | WB_W | Head write-buffer index |

## Verification
The hardest case to reach is a collision entry that sits behind entries the new command would otherwise overtake. Only then does the collision bound change the outcome instead of matching the head lock. The stimulus builds a four-entry queue in which the colliding entry is second and an entry with a different field is third, then pushes an urgent command. The same sequence is repeated with the rule disabled to show the different slot. The pop-and-push cycle is reached by holding out_ready_i low until the queue is full, then raising both valids in one cycle. A placement variant of this case lets the urgent command take the vacated head slot.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  parameter int unsigned BANK_W = 3;
  parameter int unsigned ROW_W  = 8;
  parameter int unsigned COL_W  = 8;
  parameter int unsigned SRC_W  = 4;
  parameter int unsigned PRIO_W = 2;
  parameter int unsigned WB_W   = 3;

  localparam int unsigned RULE_N = 6;
  // collision rules occupy the low half, ordering rules the high half
  localparam int unsigned COLL_N = 3;
  localparam int unsigned ORD_N  = RULE_N - COLL_N;

  typedef struct packed {
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [SRC_W-1:0]  src;
    logic [PRIO_W-1:0] prio;
    logic [WB_W-1:0]   wb;
  } cmd_t;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [CNT_W-1:0] pos_i,
  input  cmd_t             cmd_i,
  output cmd_t             view_o [DEPTH],
  output logic [CNT_W-1:0] cnt_view_o,
  output logic [CNT_W-1:0] cnt_o,
  output cmd_t             head_o
);
  cmd_t             q_q [DEPTH];
  cmd_t             nxt [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  assign cnt_view_o = cnt_q - CNT_W'(pop_i);
  assign cnt_o      = cnt_q;
  assign head_o     = q_q[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    // view: contents as seen after this cycle's pop
    if (i < DEPTH - 1) begin : g_mid
      assign view_o[i] = pop_i ? q_q[i+1] : q_q[i];
    end else begin : g_last
      assign view_o[i] = pop_i ? '0 : q_q[i];
    end
    if (i == 0) begin : g_first
      assign nxt[i] = (push_i && pos_i == '0) ? cmd_i : view_o[i];
    end else begin : g_rest
      always_comb begin
        if (!push_i || pos_i > CNT_W'(i)) nxt[i] = view_o[i];
        else if (pos_i == CNT_W'(i))      nxt[i] = cmd_i;
        else                              nxt[i] = view_o[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
    end else if (push_i || pop_i) begin
      cnt_q <= cnt_view_o + CNT_W'(push_i);
      for (int i = 0; i < DEPTH; i++) q_q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/cmdq_match.sv
module cmdq_match
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  cmd_t              view_i [DEPTH],
  input  logic [CNT_W-1:0]  cnt_view_i,
  input  cmd_t              cmd_i,
  input  logic [COLL_N-1:0] coll_en_i,
  output logic [DEPTH-1:0]  coll_o,
  output logic [DEPTH-1:0]  less_o,
  output logic [DEPTH-1:0]  more_o,
  output logic [DEPTH-1:0]  bank_eq_o,
  output logic [DEPTH-1:0]  wr_eq_o
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic live, addr_hit, src_hit, wb_hit;
    assign live     = CNT_W'(i) < cnt_view_i;
    assign addr_hit = coll_en_i[0] && view_i[i].bank == cmd_i.bank && view_i[i].row == cmd_i.row;
    assign src_hit  = coll_en_i[1] && view_i[i].src == cmd_i.src;
    assign wb_hit   = coll_en_i[2] && view_i[i].wb == cmd_i.wb;
    assign coll_o[i]    = live && (addr_hit || src_hit || wb_hit);
    assign less_o[i]    = live && view_i[i].prio < cmd_i.prio;
    assign more_o[i]    = live && view_i[i].prio > cmd_i.prio;
    assign bank_eq_o[i] = live && view_i[i].bank == cmd_i.bank;
    assign wr_eq_o[i]   = live && view_i[i].wr == cmd_i.wr;
  end
endmodule

// File: rtl/cmdq_place.sv
module cmdq_place
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             place_en_i,
  input  logic [ORD_N-1:0] ord_en_i,   // 0 priority, 1 bank split, 2 rw group
  input  logic             lock_i,     // offered head may not be displaced
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [DEPTH-1:0] coll_i,
  input  logic [DEPTH-1:0] less_i,
  input  logic [DEPTH-1:0] more_i,
  input  logic [DEPTH-1:0] bank_eq_i,
  input  logic [DEPTH-1:0] wr_eq_i,
  output logic [CNT_W-1:0] pos_o
);
  logic [DEPTH:0] pred_bank, pred_wr, succ_wr;
  int lb, t, s, best, sc, best_sc;
  logic found;

  assign pred_bank = {bank_eq_i, 1'b0};
  assign pred_wr   = {wr_eq_i, 1'b0};
  assign succ_wr   = {1'b0, wr_eq_i};

  always_comb begin
    // lower bound from collisions
    lb = 0;
    for (int i = 0; i < DEPTH; i++) if (coll_i[i]) lb = i + 1;
    if (lock_i && lb == 0) lb = 1;
    // priority target
    t = int'(cnt_i);
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ord_en_i[0] && !found && i >= lb && more_i[i]) begin
        t = i;
        found = 1'b1;
      end
    end
    // start of the equal-priority window
    s = lb;
    for (int i = 0; i < DEPTH; i++)
      if (ord_en_i[0] && i >= lb && i < t && less_i[i]) s = i + 1;
    // tie breaking, latest wins
    best = t;
    best_sc = -1;
    sc = 0;
    for (int p = 0; p <= DEPTH; p++) begin
      if (p >= s && p <= t) begin
        sc = 0;
        if (ord_en_i[1] && !pred_bank[p]) sc = sc + 2;
        if (ord_en_i[2] && (pred_wr[p] || succ_wr[p])) sc = sc + 1;
        if (sc >= best_sc) begin
          best = p;
          best_sc = sc;
        end
      end
    end
    pos_o = place_en_i ? CNT_W'(best) : cnt_i;
  end
endmodule

// File: rtl/reorder_cmdq.sv
module reorder_cmdq
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              place_en_i,
  input  logic [RULE_N-1:0] rule_en_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_wr_i,
  input  logic [BANK_W-1:0] in_bank_i,
  input  logic [ROW_W-1:0]  in_row_i,
  input  logic [COL_W-1:0]  in_col_i,
  input  logic [SRC_W-1:0]  in_src_i,
  input  logic [PRIO_W-1:0] in_prio_i,
  input  logic [WB_W-1:0]   in_wb_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_wr_o,
  output logic [BANK_W-1:0] out_bank_o,
  output logic [ROW_W-1:0]  out_row_o,
  output logic [COL_W-1:0]  out_col_o,
  output logic [SRC_W-1:0]  out_src_o,
  output logic [PRIO_W-1:0] out_prio_o,
  output logic [WB_W-1:0]   out_wb_o
);
  cmd_t             new_cmd, head;
  cmd_t             view [DEPTH];
  logic [CNT_W-1:0] cnt, cnt_view, pos;
  logic             push, pop, lock;
  logic [DEPTH-1:0] coll, less, more, bank_eq, wr_eq;

  assign new_cmd = '{wr: in_wr_i, bank: in_bank_i, row: in_row_i, col: in_col_i,
                     src: in_src_i, prio: in_prio_i, wb: in_wb_i};

  assign pop        = out_ready_i && cnt != '0;
  assign in_ready_o = cnt != CNT_W'(DEPTH) || out_ready_i;
  assign push       = in_valid_i && in_ready_o;
  assign lock       = !pop && cnt != '0;

  cmdq_store #(.DEPTH(DEPTH)) i_store (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .pos_i(pos), .cmd_i(new_cmd),
    .view_o(view), .cnt_view_o(cnt_view), .cnt_o(cnt), .head_o(head)
  );

  cmdq_match #(.DEPTH(DEPTH)) i_match (
    .view_i(view), .cnt_view_i(cnt_view), .cmd_i(new_cmd),
    .coll_en_i(rule_en_i[COLL_N-1:0]),
    .coll_o(coll), .less_o(less), .more_o(more), .bank_eq_o(bank_eq), .wr_eq_o(wr_eq)
  );

  cmdq_place #(.DEPTH(DEPTH)) i_place (
    .place_en_i, .ord_en_i(rule_en_i[RULE_N-1:COLL_N]), .lock_i(lock), .cnt_i(cnt_view),
    .coll_i(coll), .less_i(less), .more_i(more), .bank_eq_i(bank_eq), .wr_eq_i(wr_eq),
    .pos_o(pos)
  );

  assign out_valid_o = cnt != '0;
  assign out_wr_o    = head.wr;
  assign out_bank_o  = head.bank;
  assign out_row_o   = head.row;
  assign out_col_o   = head.col;
  assign out_src_o   = head.src;
  assign out_prio_o  = head.prio;
  assign out_wb_o    = head.wb;
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker
  import cmdq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [CNT_W-1:0] cnt,
  input cmd_t             new_cmd,
  input cmd_t             head
);
  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(DEPTH));

  p_full_block_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == CNT_W'(DEPTH) && !out_ready_i |-> !in_ready_o);

  p_full_swap_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == CNT_W'(DEPTH) && out_ready_i && in_valid_i |=> cnt == CNT_W'(DEPTH));

  p_head_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(head));

  p_empty_push_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == '0 && in_valid_i && in_ready_o |=> out_valid_o && head == $past(new_cmd));
endmodule

bind reorder_cmdq cmdq_checker #(.DEPTH(DEPTH)) i_chk (
  .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .out_valid_o, .out_ready_i,
  .cnt, .new_cmd, .head
);

// File: tb/test_reorder_cmdq.sv
`timescale 1ns/1ps
module test_reorder_cmdq;
  import cmdq_pkg::*;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              place_en = 1'b0;
  logic [RULE_N-1:0] rule_en = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_wr = 1'b0;
  logic [BANK_W-1:0] in_bank = '0;
  logic [ROW_W-1:0]  in_row = '0;
  logic [COL_W-1:0]  in_col = '0;
  logic [SRC_W-1:0]  in_src = '0;
  logic [PRIO_W-1:0] in_prio = '0;
  logic [WB_W-1:0]   in_wb = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic              out_wr;
  logic [BANK_W-1:0] out_bank;
  logic [ROW_W-1:0]  out_row;
  logic [COL_W-1:0]  out_col;
  logic [SRC_W-1:0]  out_src;
  logic [PRIO_W-1:0] out_prio;
  logic [WB_W-1:0]   out_wb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reorder_cmdq #(.DEPTH(8)) i_reorder_cmdq (
    .clk_i(clk), .rst_ni, .place_en_i(place_en), .rule_en_i(rule_en),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_wr_i(in_wr), .in_bank_i(in_bank),
    .in_row_i(in_row), .in_col_i(in_col), .in_src_i(in_src), .in_prio_i(in_prio),
    .in_wb_i(in_wb), .out_valid_o(out_valid), .out_ready_i(out_ready), .out_wr_o(out_wr),
    .out_bank_o(out_bank), .out_row_o(out_row), .out_col_o(out_col), .out_src_o(out_src),
    .out_prio_o(out_prio), .out_wb_o(out_wb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at a falling edge, one cycle
  task automatic set_cmd(input bit wr, input int bank, input int row, input int col,
                         input int src, input int prio, input int wb);
    in_wr = wr; in_bank = BANK_W'(bank); in_row = ROW_W'(row); in_col = COL_W'(col);
    in_src = SRC_W'(src); in_prio = PRIO_W'(prio); in_wb = WB_W'(wb);
  endtask

  task automatic push(input bit wr, input int bank, input int row, input int col,
                      input int src, input int prio, input int wb);
    set_cmd(wr, bank, row, col, src, prio, wb);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input int exp [8], input int n, input string req);
    for (int k = 0; k < n; k++) begin
      chk(out_valid && int'(out_col) == exp[k], req, out_valid ? int'(out_col) : -1, exp[k]);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(!out_valid, req, int'(out_valid), 0);
  endtask

  task automatic t_reset;
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
  endtask

  task automatic t_fifo;
    place_en = 1'b0; rule_en = '1;
    push(0, 1, 4, 1, 2, 3, 1);
    chk(out_valid && out_col == 1, "R3 empty push head", int'(out_col), 1);
    push(1, 1, 4, 2, 2, 0, 1);
    push(0, 1, 4, 3, 2, 1, 1);
    drain('{1, 2, 3, 0, 0, 0, 0, 0}, 3, "R2 fifo order");
  endtask

  task automatic t_prio;
    place_en = 1'b1; rule_en = 6'b001000;
    push(0, 0, 0, 1, 0, 2, 0);
    push(0, 1, 0, 2, 1, 1, 1);
    push(0, 2, 0, 3, 2, 0, 2);
    push(0, 3, 0, 4, 3, 1, 3);
    chk(out_col == 1, "R4 head kept", int'(out_col), 1);
    drain('{1, 3, 2, 4, 0, 0, 0, 0}, 4, "R8 priority order");
  endtask

  // k: 0 address, 1 source, 2 write buffer
  task automatic t_coll(input int k, input bit on, input string req);
    place_en = 1'b1; rule_en = on ? RULE_N'((1 << k) | 8) : 6'b001000;
    push(0, 0, 0, 1, 0, 3, 0);
    push(0, 1, 5, 2, 1, 3, 1);
    push(0, 2, 0, 3, 2, 3, 2);
    push(0, k == 0 ? 1 : 3, k == 0 ? 5 : 9, 4, k == 1 ? 1 : 7, 0, k == 2 ? 1 : 6);
    if (on) drain('{1, 2, 4, 3, 0, 0, 0, 0}, 4, req);
    else    drain('{1, 4, 2, 3, 0, 0, 0, 0}, 4, req);
  endtask

  task automatic t_bank(input bit on);
    place_en = 1'b1; rule_en = on ? 6'b011000 : 6'b001000;
    push(0, 0, 0, 1, 0, 0, 0);
    push(0, 1, 0, 2, 1, 1, 1);
    push(0, 2, 0, 3, 2, 1, 2);
    push(0, 2, 1, 4, 3, 1, 3);
    if (on) drain('{1, 2, 4, 3, 0, 0, 0, 0}, 4, "R9 bank split");
    else    drain('{1, 2, 3, 4, 0, 0, 0, 0}, 4, "R9 bank rule off");
  endtask

  task automatic t_rw;
    place_en = 1'b1; rule_en = 6'b100000;
    push(0, 0, 0, 1, 0, 1, 0);
    push(1, 1, 0, 2, 1, 1, 1);
    push(0, 2, 0, 3, 2, 1, 2);
    push(1, 3, 0, 4, 3, 1, 3);
    drain('{1, 3, 2, 4, 0, 0, 0, 0}, 4, "R10 rw grouping");
  endtask

  task automatic t_full;
    place_en = 1'b0; rule_en = '0;
    for (int i = 0; i < 8; i++) push(0, i % 8, 0, 10 + i, i, 0, i % 8);
    chk(in_ready == 1'b0, "R11 full ready", int'(in_ready), 0);
    push(0, 0, 0, 99, 0, 0, 0);
    set_cmd(0, 0, 0, 18, 0, 0, 0);
    in_valid = 1'b1; out_ready = 1'b1;
    #1 chk(in_ready == 1'b1, "R12 swap ready", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk(out_col == 11, "R12 head after swap", int'(out_col), 11);
    drain('{11, 12, 13, 14, 15, 16, 17, 18}, 8, "R11 R12 drained");
  endtask

  task automatic t_swap_place;
    place_en = 1'b1; rule_en = 6'b001000;
    push(0, 0, 0, 1, 0, 2, 0);
    push(0, 1, 0, 2, 1, 2, 1);
    set_cmd(0, 2, 0, 3, 2, 0, 2);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    drain('{3, 2, 0, 0, 0, 0, 0, 0}, 2, "R4 R3 insert at new head");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #9 rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_fifo();
    t_prio();
    t_coll(0, 1'b1, "R5 address bound");
    t_coll(0, 1'b0, "R5 address rule off");
    t_coll(1, 1'b1, "R6 source bound");
    t_coll(2, 1'b1, "R7 write buffer bound");
    t_bank(1'b1);
    t_bank(1'b0);
    t_rw();
    t_full();
    t_swap_place();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule